// File: doc/BRIEF.md
# Reset-Entry Bus Sequencer

This block drives the first bus cycles of a byte-wide processor with a 32-bit address space after it leaves reset. It owns the address bus, the write strobe and the outgoing data byte, and it watches the incoming data byte. Once reset drops, it saves the processor's current program counter and its status byte to the stack page. It then reads a four-byte start address from a fixed location near the top of memory and issues the first two opcode fetches from that address.

The stack lives at page one, so a push goes to 0x100 plus an 8-bit stack pointer. The pointer starts at 0x00 and moves down by one after every push, wrapping within 8 bits. The memory system returns read data one clock after the address appears. A ready input lets slow memory stretch any read cycle. Write cycles never wait for it.

Top module: `rst_entry_seq`

## Requirements
- R1: While `rst` is high, `bus_we` and `opfetch` are low, `bus_addr` is 0 and `stack_ptr` is 0x00. The cycle after `rst` drops is still idle. The first push appears after the first rising edge at which `rst` is sampled low.
- R2: The five pushes come in consecutive cycles at addresses 0x100, 0x1FF, 0x1FE, 0x1FD and 0x1FC, with `bus_we` high in each.
- R3: The push data is `cur_pc[31:24]`, then `[23:16]`, then `[15:8]`, then `[7:0]`, and finally `cur_status`.
- R4: In each push cycle, `stack_ptr` equals the low byte of the push address. It drops by one, modulo 256, after every push and is 0xFB once the pushes end.
- R5: The cycle after the last push begins four read cycles, with `bus_we` low, at 0xFFFFFFF4, 0xFFFFFFF5, 0xFFFFFFF6 and 0xFFFFFFF7, in that order.
- R6: Each vector byte is taken from `din` one clock after its address was driven. The bytes are assembled little-endian: the byte from 0xFFFFFFF4 becomes bits 7:0. The assembled value appears on `prog_ctr`.
- R7: The cycle after the last vector read drives the assembled vector on `bus_addr` with `opfetch` high. The next cycle drives vector+1 with `opfetch` high. Within the first fetch cycle, the top vector byte comes straight from `din`.
- R8: When `rdy` is low during a vector read or opfetch cycle, the sequencer keeps that cycle's address and position. The assembled vector is unaffected.
- R9: `rdy` has no effect during push cycles: all five pushes complete back to back.
- R10: After the second fetch, the sequencer stops with `bus_we` and `opfetch` low and `bus_addr` held at vector+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy | input | 1 | Memory ready; low stretches read cycles |
| din | input | 8 | Read data, valid one clock after its address |
| cur_pc | input | 32 | Program counter value to save |
| cur_status | input | 8 | Status byte to save |
| bus_addr | output | 32 | Bus address |
| bus_we | output | 1 | Write strobe |
| bus_dout | output | 8 | Write data |
| opfetch | output | 1 | High in the two opcode fetch cycles |
| stack_ptr | output | 8 | Stack pointer |
| prog_ctr | output | 32 | Assembled start address |

## Verification
The top vector byte arrives on `din` in the same cycle as the first opcode fetch, which must already drive the complete vector. Capture and address formation therefore overlap in one clock. The bench provokes this by holding `rdy` low across that fetch cycle and across the last vector read, so the byte must be correct both when it is taken straight from the input and when it is taken from the register a cycle later. Each cycle is judged against an address computed from the sweep's vector. The bench also compares `prog_ctr` after the sequence ends.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PUSH,
      PH_VEC,
      PH_FETCH,
      PH_DONE
   } seq_phase_e;
endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rst_seq_pkg::*;
#(
   parameter int PC_BYTES = 4,
   parameter int IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rdy,
   output seq_phase_e       phase,
   output logic [IDX_W-1:0] idx,
   output logic             cap_vld,
   output logic [IDX_W-1:0] cap_idx
);
   localparam logic [IDX_W-1:0] LAST_PUSH  = IDX_W'(PC_BYTES);
   localparam logic [IDX_W-1:0] LAST_VEC   = IDX_W'(PC_BYTES - 1);
   localparam logic [IDX_W-1:0] LAST_FETCH = IDX_W'(1);
   localparam logic [IDX_W-1:0] ONE        = IDX_W'(1);

   if (PC_BYTES < 1) begin : g_bad_bytes
      $error("rst_seq_ctrl: PC_BYTES must be at least 1");
   end
   if ((1 << IDX_W) <= PC_BYTES) begin : g_bad_idx
      $error("rst_seq_ctrl: IDX_W too narrow for PC_BYTES");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         idx   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               phase <= PH_PUSH;
               idx   <= '0;
            end
            PH_PUSH: begin
               if (idx == LAST_PUSH) begin
                  phase <= PH_VEC;
                  idx   <= '0;
               end else begin
                  idx <= idx + ONE;
               end
            end
            PH_VEC: begin
               if (rdy) begin
                  if (idx == LAST_VEC) begin
                     phase <= PH_FETCH;
                     idx   <= '0;
                  end else begin
                     idx <= idx + ONE;
                  end
               end
            end
            PH_FETCH: begin
               if (rdy) begin
                  if (idx == LAST_FETCH) begin
                     phase <= PH_DONE;
                  end else begin
                     idx <= idx + ONE;
                  end
               end
            end
            default: begin
               phase <= PH_DONE;
            end
         endcase
      end
   end

   // A vector read that completes this cycle returns its byte next cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         cap_vld <= 1'b0;
         cap_idx <= '0;
      end else begin
         cap_vld <= (phase == PH_VEC) && rdy;
         cap_idx <= idx;
      end
   end
endmodule

// File: rtl/rst_seq_stack.sv
module rst_seq_stack #(
   parameter int              ADDR_W   = 32,
   parameter int              DATA_W   = 8,
   parameter int              PC_BYTES = 4,
   parameter int              IDX_W    = 3,
   parameter int              SP_W     = 8,
   parameter logic [SP_W-1:0] SP_INIT  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] cur_status,
   output logic [SP_W-1:0]   sp,
   output logic [DATA_W-1:0] push_data
);
   if (PC_BYTES * DATA_W != ADDR_W) begin : g_bad_split
      $error("rst_seq_stack: PC_BYTES * DATA_W must equal ADDR_W");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sp <= SP_INIT;
      end else if (push) begin
         sp <= sp - SP_W'(1);
      end
   end

   // Highest program-counter byte goes out first, status byte last.
   always_comb begin
      int sel;
      sel = PC_BYTES - 1 - int'(idx);
      if (int'(idx) < PC_BYTES) begin
         push_data = cur_pc[sel*DATA_W +: DATA_W];
      end else begin
         push_data = cur_status;
      end
   end
endmodule

// File: rtl/rst_seq_vec.sv
module rst_seq_vec #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 8,
   parameter int PC_BYTES = 4,
   parameter int IDX_W    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_vld,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] vec_q,
   output logic [ADDR_W-1:0] vec_live
);
   for (genvar b = 0; b < PC_BYTES; b++) begin : g_byte
      logic              hit;
      logic [DATA_W-1:0] q;

      assign hit = cap_vld && (cap_idx == IDX_W'(b));

      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (hit) begin
            q <= din;
         end
      end

      assign vec_q[b*DATA_W +: DATA_W]    = q;
      // The byte arriving this cycle is forwarded ahead of its register.
      assign vec_live[b*DATA_W +: DATA_W] = hit ? din : q;
   end
endmodule

// File: rtl/rst_entry_seq.sv
module rst_entry_seq
   import rst_seq_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 8,
   parameter int                SP_W       = 8,
   parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0100,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 32'hFFFF_FFF4,
   parameter logic [SP_W-1:0]   SP_INIT    = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rdy,
   input  logic [DATA_W-1:0] din,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] cur_status,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_dout,
   output logic              opfetch,
   output logic [SP_W-1:0]   stack_ptr,
   output logic [ADDR_W-1:0] prog_ctr
);
   localparam int PC_BYTES = ADDR_W / DATA_W;
   localparam int IDX_W    = $clog2(PC_BYTES + 1);

   if (ADDR_W % DATA_W != 0) begin : g_bad_width
      $error("rst_entry_seq: ADDR_W must be a multiple of DATA_W");
   end
   if (SP_W >= ADDR_W) begin : g_bad_sp
      $error("rst_entry_seq: SP_W must be narrower than ADDR_W");
   end

   seq_phase_e        phase;
   logic [IDX_W-1:0]  idx;
   logic              cap_vld;
   logic [IDX_W-1:0]  cap_idx;
   logic [SP_W-1:0]   sp;
   logic [DATA_W-1:0] push_data;
   logic [ADDR_W-1:0] vec_q;
   logic [ADDR_W-1:0] vec_live;

   rst_seq_ctrl #(
      .PC_BYTES (PC_BYTES),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .rdy     (rdy),
      .phase   (phase),
      .idx     (idx),
      .cap_vld (cap_vld),
      .cap_idx (cap_idx)
   );

   rst_seq_stack #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PC_BYTES (PC_BYTES),
      .IDX_W    (IDX_W),
      .SP_W     (SP_W),
      .SP_INIT  (SP_INIT)
   ) u_stack (
      .clk        (clk),
      .rst        (rst),
      .push       (phase == PH_PUSH),
      .idx        (idx),
      .cur_pc     (cur_pc),
      .cur_status (cur_status),
      .sp         (sp),
      .push_data  (push_data)
   );

   rst_seq_vec #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PC_BYTES (PC_BYTES),
      .IDX_W    (IDX_W)
   ) u_vec (
      .clk      (clk),
      .rst      (rst),
      .cap_vld  (cap_vld),
      .cap_idx  (cap_idx),
      .din      (din),
      .vec_q    (vec_q),
      .vec_live (vec_live)
   );

   always_comb begin
      unique case (phase)
         PH_PUSH:  bus_addr = STACK_BASE + ADDR_W'(sp);
         PH_VEC:   bus_addr = VEC_BASE + ADDR_W'(idx);
         PH_FETCH: bus_addr = vec_live + ADDR_W'(idx);
         PH_DONE:  bus_addr = vec_q + ADDR_W'(1);
         default:  bus_addr = '0;
      endcase
   end

   assign bus_we    = (phase == PH_PUSH);
   assign bus_dout  = (phase == PH_PUSH) ? push_data : '0;
   assign opfetch   = (phase == PH_FETCH);
   assign stack_ptr = sp;
   assign prog_ctr  = vec_q;
endmodule

// File: rtl/rst_entry_seq_chk.sv
module rst_entry_seq_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 8,
   parameter int                SP_W       = 8,
   parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0100,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 32'hFFFF_FFF4
) (
   input logic              clk,
   input logic              rst,
   input logic              rdy,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              opfetch,
   input logic [SP_W-1:0]   stack_ptr
);
   localparam int PC_BYTES = ADDR_W / DATA_W;

   logic [ADDR_W-1:0] vec_off;
   logic              in_vec;
   logic              rd_cycle;

   assign vec_off  = bus_addr - VEC_BASE;
   assign in_vec   = !bus_we && !opfetch && (vec_off < ADDR_W'(PC_BYTES));
   assign rd_cycle = opfetch || in_vec;

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!bus_we && !opfetch));  // R1

   AST_PUSH_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
      bus_we |-> (bus_addr[ADDR_W-1:SP_W] == STACK_BASE[ADDR_W-1:SP_W]));  // R2

   AST_PUSH_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
      (bus_we && $past(bus_we)) |-> (bus_addr[SP_W-1:0] == $past(bus_addr[SP_W-1:0]) - SP_W'(1)));  // R2

   AST_SP_MOVES_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
      $past(bus_we) |-> (stack_ptr == $past(stack_ptr) - SP_W'(1)));  // R4

   AST_SP_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
      (!$past(bus_we) && !$past(rst)) |-> $stable(stack_ptr));  // R4

   AST_VEC_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_we) && !bus_we) |-> (bus_addr == VEC_BASE));  // R5

   AST_FETCH_NEXT: assert property (@(posedge clk) disable iff (rst)
      (opfetch && $past(opfetch) && $past(rdy)) |-> (bus_addr == $past(bus_addr) + ADDR_W'(1)));  // R7

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      $past(!rdy && rd_cycle) |-> $stable(bus_addr));  // R8

   AST_PUSH_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
      $past(bus_we) |-> (bus_addr != $past(bus_addr)));  // R9
endmodule

bind rst_entry_seq rst_entry_seq_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .SP_W       (SP_W),
   .STACK_BASE (STACK_BASE),
   .VEC_BASE   (VEC_BASE)
) u_chk (.*);

// File: tb/rst_entry_seq_tb.sv
`timescale 1ns/1ps
module rst_entry_seq_tb;
   localparam logic [31:0] VBASE = 32'hFFFF_FFF4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rdy = 1'b1;
   logic [7:0]  din = 8'h00;
   logic [31:0] cur_pc = '0;
   logic [7:0]  cur_status = '0;
   logic [31:0] bus_addr;
   logic        bus_we;
   logic [7:0]  bus_dout;
   logic        opfetch;
   logic [7:0]  stack_ptr;
   logic [31:0] prog_ctr;

   int          n_tests = 0;
   int          n_fail  = 0;
   logic [31:0] vec_cfg = '0;

   always #5 clk = ~clk;

   rst_entry_seq u_dut (
      .clk        (clk),
      .rst        (rst),
      .rdy        (rdy),
      .din        (din),
      .cur_pc     (cur_pc),
      .cur_status (cur_status),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_dout   (bus_dout),
      .opfetch    (opfetch),
      .stack_ptr  (stack_ptr),
      .prog_ctr   (prog_ctr)
   );

   function automatic logic [7:0] mem_rd(input logic [31:0] a);
      logic [31:0] off;
      off = a - VBASE;
      if (off < 32'd4) return vec_cfg[off[1:0]*8 +: 8];
      return a[7:0] ^ 8'h5A;
   endfunction

   // Memory answers one clock after the address.
   always_ff @(posedge clk) din <= mem_rd(bus_addr);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_cfg(input int cfg);
      logic [31:0] mask;
      int          j;
      int          cyc;
      bit          prev_stall;
      logic [31:0] exp_a;
      logic [7:0]  exp_d;
      cur_pc     = 32'hA1B2_C3D4 + 32'(cfg) * 32'h1111_1111;
      cur_status = 8'(cfg * 37 + 3);
      vec_cfg    = (cfg == 1) ? 32'hFFFF_FFFF : (32'h1357_9BDF ^ (32'(cfg) * 32'h0101_0307));
      case (cfg)
         0:       mask = 32'h0;
         1:       mask = 32'h0000_001F;             // stalls over the pushes
         2:       mask = 32'h0000_0600;             // stalls at first fetch
         3:       mask = 32'hFFFF_FFE0;             // long stalls on reads
         4:       mask = 32'h0000_0100;             // stall on last vector read
         default: mask = (32'h9E37_79B9 * 32'(cfg)) ^ (32'(cfg) << 7);
      endcase
      rst = 1'b1;
      rdy = 1'b1;
      repeat (3) @(negedge clk);
      chk(bus_we == 1'b0,     "R1", "we in reset",    32'(bus_we), 32'h0);
      chk(bus_addr == 32'h0,  "R1", "addr in reset",  bus_addr, 32'h0);
      chk(opfetch == 1'b0,    "R1", "fetch in reset", 32'(opfetch), 32'h0);
      chk(stack_ptr == 8'h00, "R1", "sp in reset",    32'(stack_ptr), 32'h0);
      rst = 1'b0;
      #1;
      chk(bus_we == 1'b0 && bus_addr == 32'h0, "R1", "idle after release", bus_addr, 32'h0);
      j = 0;
      cyc = 0;
      prev_stall = 1'b0;
      while (j < 11 && cyc < 100) begin
         @(negedge clk);
         rdy = (cyc < 32) ? !mask[cyc] : 1'b1;
         if (j < 5) begin
            exp_a = 32'h100 + 32'(8'(8'h00 - 8'(j)));
            exp_d = (j < 4) ? cur_pc[(3 - j)*8 +: 8] : cur_status;
            chk(bus_addr == exp_a && bus_we, rdy ? "R2" : "R9", "push addr", bus_addr, exp_a);
            chk(bus_dout == exp_d, "R3", "push data", 32'(bus_dout), 32'(exp_d));
            chk(stack_ptr == exp_a[7:0], "R4", "sp at push", 32'(stack_ptr), 32'(exp_a[7:0]));
         end else if (j < 9) begin
            exp_a = VBASE + 32'(j - 5);
            chk(bus_addr == exp_a && !bus_we && !opfetch, prev_stall ? "R8" : "R5",
                "vector read addr", bus_addr, exp_a);
         end else begin
            exp_a = vec_cfg + 32'(j - 9);
            chk(bus_addr == exp_a && opfetch && !bus_we, prev_stall ? "R8" : "R7",
                "fetch addr", bus_addr, exp_a);
         end
         prev_stall = (j >= 5) && !rdy;
         if (j < 5 || rdy) j++;
         cyc++;
      end
      @(negedge clk);
      chk(bus_addr == vec_cfg + 32'h1 && !bus_we && !opfetch, "R10", "final hold",
          bus_addr, vec_cfg + 32'h1);
      chk(prog_ctr == vec_cfg, "R6", "assembled vector", prog_ctr, vec_cfg);
      chk(stack_ptr == 8'hFB, "R4", "final sp", 32'(stack_ptr), 32'hFB);
      @(negedge clk);
      chk(bus_addr == vec_cfg + 32'h1, "R10", "still held", bus_addr, vec_cfg + 32'h1);
   endtask

   initial begin
      for (int cfg = 0; cfg < 16; cfg++) run_cfg(cfg);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(1_000_000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule